// File: doc/BRIEF.md
# Buzzer Output Mode Generator

This block drives one buzzer pin. A two-bit mode field, held in an 8-bit configuration register, selects one of three things for the pin: a steady low level, a steady high level, or a symmetric square wave. The square wave is timed by a 16-bit divisor register. The pin stays in each level for the divisor plus two clock cycles, so the output frequency is the clock frequency divided by 2 × (divisor + 2).

Software reaches the block through two write strobes, each with its own data bus: one for the configuration byte and one for the divisor. There is no read path. Writing the divisor restarts the wave with the pin low. Switching into square-wave mode also restarts the wave with the pin low. A write that sets square-wave mode while that mode is already active leaves the wave running as it was.

Top module: `buzzer_gen`

## Requirements
- R1: After a synchronous active-low reset, the mode is 00, the divisor is 0 and the pin is low.
- R2: The mode field is bits 7:6 of the configuration write data. Bits 5:0 have no effect on the pin.
- R3: In mode 00 the pin is low from the clock edge after the configuration write.
- R4: In mode 01 the pin is high from the clock edge after the configuration write.
- R5: Mode 11 is reserved and drives the pin low, the same as mode 00.
- R6: In mode 10 the pin alternates low and high, and each level lasts exactly divisor + 2 clock cycles, for divisor values 0 through 65535.
- R7: Entering mode 10 from any other mode drives the pin low from the next edge. The first low phase then lasts divisor + 2 cycles.
- R8: A divisor write drives the pin low from the next edge and restarts the wave, timed by the new divisor.
- R9: Writing mode 10 while mode 10 is already active does not disturb the phase in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 8 | Configuration data; bits 7:6 hold the mode |
| div_we | input | 1 | Divisor register write strobe |
| div_wdata | input | 16 | Divisor write data |
| buz_out | output | 1 | Buzzer pin |

## Verification
The wave is measured for divisors 0, 1, 2, 9 and 300. The bench counts the length of the first low run, the following high run and the next low run.
- Divisors 0 and 1 separate an off-by-one in the terminal count from a correct reload.
- The larger divisors expose any truncation in the counter.
- Comparing a low run with a high run exposes asymmetric phases.

The static modes are written with the reserved bits both set and clear, which shows that only bits 7:6 are decoded. Writes in the middle of a phase separate a restart (after a divisor write) from an undisturbed phase (after a repeated mode-10 write).

// File: rtl/buzzer_pkg.sv
// Package: shared widths and the mode encoding for the buzzer generator.
// Assumes the mode field sits in bits 7:6 of an 8-bit configuration byte.
package buzzer_pkg;
    localparam int CFG_W    = 8;
    localparam int MODE_LSB = 6;
    localparam int MODE_W   = 2;

    typedef enum logic [MODE_W-1:0] {
        BZ_LOW  = 2'b00,
        BZ_HIGH = 2'b01,
        BZ_WAVE = 2'b10,
        BZ_RSVD = 2'b11
    } bz_mode_e;
endpackage

// File: rtl/buzzer_mode_reg.sv
// Module: holds the buzzer mode field taken from configuration writes.
// It also flags a write that moves the block into square-wave mode from any
// other mode. Assumes a synchronous active-low reset.
module buzzer_mode_reg
    import buzzer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output bz_mode_e         mode,
    output logic             enter_wave
);
    bz_mode_e mode_q;
    bz_mode_e mode_d;

    // Decode the mode field of the incoming write data.
    always_comb begin
        mode_d = bz_mode_e'(wdata[MODE_LSB +: MODE_W]);
    end

    // Raise a flag only for a transition into wave mode.
    always_comb begin
        enter_wave = we && (mode_d == BZ_WAVE) && (mode_q != BZ_WAVE);
    end

    // Store the mode field; reset selects static low.
    always_ff @(posedge clk) begin
        if (!rst_n)  mode_q <= BZ_LOW;
        else if (we) mode_q <= mode_d;
    end

    assign mode = mode_q;
endmodule

// File: rtl/buzzer_div_reg.sv
// Module: holds the square-wave divisor and flags each write to it.
// Assumes a synchronous active-low reset.
module buzzer_div_reg #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [DIV_W-1:0] wdata,
    output logic [DIV_W-1:0] div,
    output logic             reload
);
    logic [DIV_W-1:0] div_q;

    // Store the divisor; it resets to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)  div_q <= '0;
        else if (we) div_q <= wdata;
    end

    assign div    = div_q;
    assign reload = we;
endmodule

// File: rtl/buzzer_halfper.sv
// Module: half-period counter and toggle flop for the square wave.
// Each level lasts div + 2 cycles. The counter is one bit wider than the
// divisor so that div + 1 never overflows. A restart clears the counter and
// the toggle. While not running, both are held cleared.
module buzzer_halfper #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             tog,
    output logic [DIV_W:0]   cnt
);
    localparam int CNT_W = DIV_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] term;
    logic             tog_q;
    logic             at_term;

    // Terminal count is div + 1, giving div + 2 cycles per phase.
    always_comb begin
        term    = {1'b0, div} + CNT_W'(1);
        at_term = (cnt_q == term);
    end

    // Advance the count and flip the level at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !run) begin
            cnt_q <= '0;
            tog_q <= 1'b0;
        end else if (at_term) begin
            cnt_q <= '0;
            tog_q <= ~tog_q;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign tog = tog_q;
    assign cnt = cnt_q;
endmodule

// File: rtl/buzzer_gen.sv
// Module: top of the buzzer output generator.
// Selects low, high or the square wave for the pin according to the mode
// register. Mode 11 is treated as low. Assumes synchronous active-low reset.
module buzzer_gen
    import buzzer_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             div_we,
    input  logic [DIV_W-1:0] div_wdata,
    output logic             buz_out
);
    bz_mode_e         mode;
    logic             enter_wave;
    logic [DIV_W-1:0] div;
    logic             reload;
    logic             restart;
    logic             run;
    logic             tog;
    logic [DIV_W:0]   cnt;

    buzzer_mode_reg u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (cfg_we),
        .wdata      (cfg_wdata),
        .mode       (mode),
        .enter_wave (enter_wave)
    );

    buzzer_div_reg #(.DIV_W(DIV_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (div_we),
        .wdata  (div_wdata),
        .div    (div),
        .reload (reload)
    );

    // The counter runs only in wave mode and restarts on either trigger.
    always_comb begin
        run     = (mode == BZ_WAVE);
        restart = enter_wave || reload;
    end

    buzzer_halfper #(.DIV_W(DIV_W)) u_hp (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (restart),
        .div     (div),
        .tog     (tog),
        .cnt     (cnt)
    );

    // Select the pin level from the current mode.
    always_comb begin
        unique case (mode)
            BZ_HIGH: buz_out = 1'b1;
            BZ_WAVE: buz_out = tog;
            default: buz_out = 1'b0;
        endcase
    end
endmodule

// File: rtl/buzzer_gen_chk.sv
// Checker: timing properties of buzzer_gen, attached by bind.
module buzzer_gen_chk #(
    parameter int DIV_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [7:0]       cfg_wdata,
    input logic             div_we,
    input logic             buz_out,
    input logic [1:0]       mode_q,
    input logic [DIV_W-1:0] div_q,
    input logic [DIV_W:0]   cnt_q
);
    // R4
    high_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_wdata[7:6] == 2'b01) |=> buz_out);

    // R3
    low_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_wdata[7:6] == 2'b00) |=> !buz_out);

    // R5
    rsvd_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_wdata[7:6] == 2'b11) |=> !buz_out);

    // R8
    div_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div_we && !cfg_we && mode_q == 2'b10) |=> !buz_out);

    // R7
    enter_wave_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_wdata[7:6] == 2'b10 && mode_q != 2'b10) |=> !buz_out);

    // R6
    hold_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 2'b10 && !cfg_we && !div_we && cnt_q != {1'b0, div_q} + 1'b1)
        |=> $stable(buz_out));

    // R6
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= {1'b0, div_q} + 1'b1);
endmodule

bind buzzer_gen buzzer_gen_chk #(.DIV_W(DIV_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .div_we    (div_we),
    .buz_out   (buz_out),
    .mode_q    (mode),
    .div_q     (div),
    .cnt_q     (cnt)
);

// File: tb/tb_buzzer_gen.sv
// Bench for buzzer_gen: table-driven wave checks, then directed cases.
module tb_buzzer_gen;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 5;
    localparam logic [15:0] DIVS [NVEC] = '{16'd0, 16'd1, 16'd2, 16'd9, 16'd300};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_wdata = 8'h00;
    logic        div_we = 1'b0;
    logic [15:0] div_wdata = 16'h0000;
    logic        buz_out;

    int n_run = 0;
    int n_fail = 0;

    buzzer_gen dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .div_we    (div_we),
        .div_wdata (div_wdata),
        .buz_out   (buz_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Write the configuration byte; returns on the negedge after the write edge.
    task automatic wr_cfg(input logic [7:0] v);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    // Write the divisor; returns on the negedge after the write edge.
    task automatic wr_div(input logic [15:0] v);
        @(negedge clk); div_we = 1'b1; div_wdata = v;
        @(negedge clk); div_we = 1'b0;
    endtask

    // Count consecutive negedge samples at level lvl, starting with the current one.
    task automatic run_len(input logic lvl, output int n);
        n = 0;
        while (buz_out == lvl && n < 70000) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        int lo, hi, lo2, h1;

        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 pin low in reset", buz_out, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R1 pin low after reset", buz_out, 0);

        // R6 R7: table of divisors, each run measured three times
        for (int i = 0; i < NVEC; i++) begin
            wr_cfg(8'h00);
            wr_div(DIVS[i]);
            wr_cfg(8'h80);
            check("R7 low right after entering wave", buz_out, 0);
            run_len(1'b0, lo);
            run_len(1'b1, hi);
            run_len(1'b0, lo2);
            check("R7 first low run", lo, DIVS[i] + 2);
            check("R6 high run", hi, DIVS[i] + 2);
            check("R6 second low run", lo2, DIVS[i] + 2);
        end

        // R4 R2: high mode, reserved bits set or clear
        wr_cfg(8'h7F);
        check("R4 R2 mode 01 with reserved ones", buz_out, 1);
        repeat (3) @(negedge clk);
        check("R4 mode 01 steady", buz_out, 1);
        wr_cfg(8'h40);
        check("R4 mode 01 clean", buz_out, 1);
        // R3 R2
        wr_cfg(8'h3F);
        check("R3 R2 mode 00 with reserved ones", buz_out, 0);
        wr_cfg(8'h40);
        // R5
        wr_cfg(8'hC0);
        check("R5 mode 11 low", buz_out, 0);
        wr_cfg(8'hFF);
        repeat (5) @(negedge clk);
        check("R5 mode 11 steady low", buz_out, 0);

        // R9: rewrite mode 10 during a high phase
        wr_cfg(8'h00);
        wr_div(16'd5);
        wr_cfg(8'h80);
        run_len(1'b0, lo);
        cfg_we = 1'b1; cfg_wdata = 8'h80;
        @(negedge clk); cfg_we = 1'b0;
        run_len(1'b1, h1);
        check("R9 high run kept despite rewrite", h1 + 1, 7);

        // R8: divisor write during a high phase restarts low
        run_len(1'b0, lo);
        div_we = 1'b1; div_wdata = 16'd3;
        @(negedge clk); div_we = 1'b0;
        check("R8 low after divisor write", buz_out, 0);
        run_len(1'b0, lo);
        run_len(1'b1, hi);
        check("R8 low run new divisor", lo, 5);
        check("R8 high run new divisor", hi, 5);

        // R1: mid-wave reset clears mode and divisor
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R1 low after mid-wave reset", buz_out, 0);
        repeat (10) @(negedge clk);
        check("R1 mode back to 00", buz_out, 0);
        wr_cfg(8'h80);
        run_len(1'b0, lo);
        run_len(1'b1, hi);
        check("R1 divisor reset to 0 (low)", lo, 2);
        check("R1 divisor reset to 0 (high)", hi, 2);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule